// File: doc/BRIEF.md
# Keyed-Reset Device Control Register

This block is one byte-wide control register that sits at a single fixed address in a small register space. It is reached over a plain parallel bus made of an address, write data, a write strobe, a read strobe and combinational read data. Four of its bits are kept and driven out to the signal chain: a filter-bypass flag, a Y-channel inversion flag, and the direction and enable of a self-test. One more bit never stores anything. Writing it as 1 sends a single-cycle pulse that tells the error logic elsewhere to drop its latched transient faults.

The two top bits of the register act as a key. The block follows them across successive writes to its address. When three writes arrive in the right order, it sends a one-cycle soft reset request to the rest of the digital logic. On the next clock edge it also clears its own stored bits and its key tracker. Any write to the register with both key bits clear aborts a sequence that has begun. Writes elsewhere in the register space are ignored.

Top module: `keyed_ctl_reg`

## Requirements
- R1: The register answers only at the address CTL_ADDR (default 0x0E), decoded on every address bit. A write with the strobe high at any other address, such as 0x8E, changes no output.
- R2: A write at CTL_ADDR stores bit3 to hp_bypass, bit2 to y_invert, bit1 to st_dir and bit0 to st_en, starting at the clock edge that accepts the write. While bus_rd is high at CTL_ADDR, bus_rdata returns these bits in the same positions. At any other time bus_rdata is 0x00.
- R3: Bits 7 to 4 of bus_rdata are always 0, whatever was written to them.
- R4: A write at CTL_ADDR with bit5 set makes clr_err_pulse high for exactly the one cycle after the write. Bit5 is not stored.
- R5: The key is bit7 (K1) and bit6 (K0). Three accepted writes with (K1,K0) = (1,0), then (1,1), then (0,1) make soft_rst_pulse high for exactly the one cycle after the third write.
- R6: An accepted write with K1=0 and K0=0 sends the tracker back to idle, so a later (0,1) does not fire the reset.
- R7: An accepted write with any other key that is not the expected next step sends the tracker to idle. A key of (1,0) always restarts the tracker at step one.
- R8: Writes to other addresses, and reads, neither advance nor abort a sequence in progress.
- R9: Bits 5 to 0 of a key write have no effect on how the sequence advances.
- R10: At the end of the cycle in which soft_rst_pulse is high, the four stored bits and the tracker are cleared. A write presented in that cycle is discarded: it stores nothing, causes no clear pulse and takes no key step.
- R11: While the external reset is held, and right after it, every output is 0 and the register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Combinational read data |
| hp_bypass | output | 1 | Filter-bypass control |
| y_invert | output | 1 | Y-channel inversion control |
| st_dir | output | 1 | Self-test direction |
| st_en | output | 1 | Self-test enable |
| clr_err_pulse | output | 1 | One-cycle request to clear latched errors |
| soft_rst_pulse | output | 1 | One-cycle soft reset request |

## Verification
The bench uses the default parameters: an 8-bit address, CTL_ADDR at 0x0E and two reset synchronizer stages. With the full 8-bit address, 0x8E can be used as an alias probe. A decoder that ignored the top address bit would then show up as a changed output. The two-stage synchronizer sets how many idle cycles the bench must wait after reset before it sends the first bus cycle. Back-to-back bus cycles let the bench put a write exactly in the cycle where the reset pulse is high.

// File: rtl/kcr_pkg.sv
package kcr_pkg;

  localparam int unsigned CTL_W   = 8;
  localparam int unsigned FIELD_W = 4;

  localparam int unsigned POS_ST_EN  = 0;
  localparam int unsigned POS_ST_DIR = 1;
  localparam int unsigned POS_YINV   = 2;
  localparam int unsigned POS_BYPASS = 3;
  localparam int unsigned POS_CLRERR = 5;
  localparam int unsigned POS_KEY0   = 6;
  localparam int unsigned POS_KEY1   = 7;

  typedef logic [1:0] key_t;

  localparam key_t KEY_ABORT = 2'b00;
  localparam key_t KEY_STEP1 = 2'b10;
  localparam key_t KEY_STEP2 = 2'b11;
  localparam key_t KEY_STEP3 = 2'b01;

  typedef enum logic [1:0] {
    TRK_IDLE   = 2'd0,
    TRK_ARMED  = 2'd1,
    TRK_PRIMED = 2'd2
  } trk_e;

  typedef struct packed {
    logic bypass;
    logic yinv;
    logic st_dir;
    logic st_en;
  } ctl_fields_t;

endpackage

// File: rtl/kcr_rst_sync.sv
module kcr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = 1'b1;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/kcr_addr_dec.sv
module kcr_addr_dec #(
  parameter int unsigned           ADDR_W   = 8,
  parameter logic [ADDR_W-1:0]     CTL_ADDR = 'h0E
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              block_wr,
  output logic              wr_ok,
  output logic              rd_ok
);

  logic hit;

  assign hit   = (bus_addr == CTL_ADDR);
  assign wr_ok = bus_wr & hit & ~block_wr;
  assign rd_ok = bus_rd & hit;

endmodule

// File: rtl/kcr_key_tracker.sv
module kcr_key_tracker
  import kcr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ok,
  input  key_t wr_key,
  input  logic kill,
  output logic fire_q
);

  trk_e st_q, st_d;
  logic fire_d;

  always_comb begin
    st_d   = st_q;
    fire_d = 1'b0;
    if (kill) begin
      st_d = TRK_IDLE;
    end else if (wr_ok) begin
      if (wr_key == KEY_STEP1) begin
        st_d = TRK_ARMED;
      end else if (st_q == TRK_ARMED && wr_key == KEY_STEP2) begin
        st_d = TRK_PRIMED;
      end else if (st_q == TRK_PRIMED && wr_key == KEY_STEP3) begin
        st_d   = TRK_IDLE;
        fire_d = 1'b1;
      end else begin
        st_d = TRK_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TRK_IDLE;
      fire_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      fire_q <= fire_d;
    end
  end

  // R5
  fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> !fire_q);

  // R5
  fire_from_primed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> $past(st_q == TRK_PRIMED && wr_key == KEY_STEP3));

  // R8
  hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ok && !kill) |=> $stable(st_q));

  // R6
  abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wr_key == KEY_ABORT) |=> (st_q == TRK_IDLE && !fire_q));

  // R10
  kill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (st_q == TRK_IDLE && !fire_q));

endmodule

// File: rtl/kcr_field_store.sv
module kcr_field_store
  import kcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ok,
  input  logic [CTL_W-1:0] wdata,
  input  logic             clear,
  output ctl_fields_t      fields_q,
  output logic             clr_err_q
);

  ctl_fields_t fields_d;
  logic        fields_en;
  logic        clr_err_d;

  always_comb begin
    fields_en = clear | wr_ok;
    fields_d  = fields_q;
    if (clear) begin
      fields_d = '0;
    end else if (wr_ok) begin
      fields_d = ctl_fields_t'(wdata[FIELD_W-1:0]);
    end
    clr_err_d = wr_ok & wdata[POS_CLRERR];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= '0;
    end else if (fields_en) begin
      fields_q <= fields_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_err_q <= 1'b0;
    else        clr_err_q <= clr_err_d;
  end

  // R10
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (fields_q == '0));

  // R4
  clr_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err_q |-> $past(wr_ok && wdata[POS_CLRERR]));

  // R2
  store_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !clear) |=> (fields_q == $past(wdata[FIELD_W-1:0])));

endmodule

// File: rtl/kcr_readback.sv
module kcr_readback
  import kcr_pkg::*;
(
  input  logic             rd_ok,
  input  ctl_fields_t      fields,
  output logic [CTL_W-1:0] rdata
);

  always_comb begin
    rdata = '0;
    if (rd_ok) begin
      rdata[POS_BYPASS] = fields.bypass;
      rdata[POS_YINV]   = fields.yinv;
      rdata[POS_ST_DIR] = fields.st_dir;
      rdata[POS_ST_EN]  = fields.st_en;
    end
  end

endmodule

// File: rtl/keyed_ctl_reg.sv
module keyed_ctl_reg
  import kcr_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR    = 'h0E,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CTL_W-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [CTL_W-1:0]  bus_rdata,
  output logic              hp_bypass,
  output logic              y_invert,
  output logic              st_dir,
  output logic              st_en,
  output logic              clr_err_pulse,
  output logic              soft_rst_pulse
);

  logic        rst_n_s;
  logic        wr_ok;
  logic        rd_ok;
  logic        fire_q;
  key_t        wr_key;
  ctl_fields_t fields_q;

  kcr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  kcr_addr_dec #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_dec (
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .block_wr (fire_q),
    .wr_ok    (wr_ok),
    .rd_ok    (rd_ok)
  );

  assign wr_key = {bus_wdata[POS_KEY1], bus_wdata[POS_KEY0]};

  kcr_key_tracker u_trk (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .wr_ok  (wr_ok),
    .wr_key (wr_key),
    .kill   (fire_q),
    .fire_q (fire_q)
  );

  kcr_field_store u_store (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_ok     (wr_ok),
    .wdata     (bus_wdata),
    .clear     (fire_q),
    .fields_q  (fields_q),
    .clr_err_q (clr_err_pulse)
  );

  kcr_readback u_rb (
    .rd_ok  (rd_ok),
    .fields (fields_q),
    .rdata  (bus_rdata)
  );

  assign hp_bypass      = fields_q.bypass;
  assign y_invert       = fields_q.yinv;
  assign st_dir         = fields_q.st_dir;
  assign st_en          = fields_q.st_en;
  assign soft_rst_pulse = fire_q;

  // R3
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_rdata[CTL_W-1:FIELD_W] == '0);

  // R1
  foreign_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_addr != CTL_ADDR && !fire_q) |=>
      $stable({hp_bypass, y_invert, st_dir, st_en}) && !clr_err_pulse);

  // R10
  pulse_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    soft_rst_pulse |=> (!clr_err_pulse && !soft_rst_pulse &&
                        {hp_bypass, y_invert, st_dir, st_en} == 4'b0000));

endmodule

// File: tb/keyed_ctl_reg_bench.sv
module keyed_ctl_reg_bench;

  localparam logic [7:0] A_CTL = 8'h0E;

  typedef struct {
    logic [3:0] bits;
    logic       clr;
    logic       rst;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_wr;
  logic       bus_rd;
  logic [7:0] bus_rdata;
  logic       hp_bypass, y_invert, st_dir, st_en;
  logic       clr_err_pulse, soft_rst_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  exp_t exp_q[$];

  logic [3:0] m_bits = 4'h0;
  int         m_trk  = 0;
  logic       m_rstq = 1'b0;
  bit         done   = 1'b0;

  always #4 clk = ~clk;

  keyed_ctl_reg u_keyed_ctl_reg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .hp_bypass(hp_bypass), .y_invert(y_invert), .st_dir(st_dir), .st_en(st_en),
    .clr_err_pulse(clr_err_pulse), .soft_rst_pulse(soft_rst_pulse)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, check read data, model the edge, queue result.
  task automatic step(input logic [7:0] a, input logic [7:0] d,
                      input logic wr, input logic rd, input string tag);
    logic       hit;
    logic [1:0] key;
    exp_t       e;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = wr; bus_rd = rd;
    #1;
    if (rd) check8({tag, " R2 R3 read"}, bus_rdata,
                   (a == A_CTL) ? {4'h0, m_bits} : 8'h00);
    @(posedge clk);
    hit   = wr && (a == A_CTL) && !m_rstq;
    key   = d[7:6];
    e.clr = hit && d[5];
    e.rst = hit && (m_trk == 2) && (key == 2'b01);
    if (m_rstq) begin
      m_bits = 4'h0; m_trk = 0;
    end else if (hit) begin
      m_bits = d[3:0];
      if (key == 2'b10)                      m_trk = 1;
      else if (m_trk == 1 && key == 2'b11)   m_trk = 2;
      else                                   m_trk = 0;
    end
    m_rstq = e.rst;
    e.bits = m_bits;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(8'h00, 8'h00, 1'b0, 1'b0, "idle");
  endtask

  task automatic wr_ctl(input logic [7:0] d, input string tag);
    step(A_CTL, d, 1'b1, 1'b0, tag);
  endtask

  task automatic rd_ctl(input string tag);
    step(A_CTL, 8'h00, 1'b0, 1'b1, tag);
  endtask

  // Monitor: pops one expected item per edge and compares the outputs.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check8({e.tag, " fields"}, {4'h0, hp_bypass, y_invert, st_dir, st_en}, {4'h0, e.bits});
        check8({e.tag, " R4 clr"}, {7'h0, clr_err_pulse}, {7'h0, e.clr});
        check8({e.tag, " R5 rst"}, {7'h0, soft_rst_pulse}, {7'h0, e.rst});
      end
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    bus_addr = A_CTL;
    #1;
    check8("R11 reset rdata", bus_rdata, 8'h00);
    check8("R11 reset outputs",
           {2'b00, hp_bypass, y_invert, st_dir, st_en, clr_err_pulse, soft_rst_pulse}, 8'h00);
    bus_rd = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    rd_ctl("R11 after reset");

    wr_ctl(8'h0F, "R2 all fields");
    rd_ctl("R2 readback F");
    wr_ctl(8'h35, "R3 R4 upper bits");
    rd_ctl("R3 upper read zero");
    wr_ctl(8'h20, "R4 clear pulse only");
    idle(1);

    step(8'h8E, 8'h0F, 1'b1, 1'b0, "R1 alias address");
    step(8'h0D, 8'h2A, 1'b1, 1'b0, "R1 other address");
    rd_ctl("R1 unchanged");

    wr_ctl(8'h85, "R5 R9 step1");
    wr_ctl(8'hCA, "R5 R9 step2");
    wr_ctl(8'h47, "R5 R9 step3");
    idle(2);
    rd_ctl("R10 cleared");

    wr_ctl(8'h80, "R6 step1");
    wr_ctl(8'hC0, "R6 step2");
    wr_ctl(8'h03, "R6 abort");
    wr_ctl(8'h40, "R6 no fire");
    idle(1);

    wr_ctl(8'h80, "R8 step1");
    step(8'h0D, 8'h00, 1'b1, 1'b0, "R8 foreign write");
    wr_ctl(8'hC0, "R8 step2");
    rd_ctl("R8 read between");
    step(8'h11, 8'h40, 1'b1, 1'b0, "R8 foreign key3");
    wr_ctl(8'h40, "R8 fire");
    idle(2);

    wr_ctl(8'hC0, "R7 wrong first");
    wr_ctl(8'h40, "R7 no fire");
    wr_ctl(8'h80, "R7 step1");
    wr_ctl(8'h40, "R7 skip step2");
    wr_ctl(8'hC0, "R7 late step2");
    wr_ctl(8'h40, "R7 still idle");
    wr_ctl(8'h80, "R7 step1 again");
    wr_ctl(8'h80, "R7 restart");
    wr_ctl(8'hC0, "R7 step2");
    wr_ctl(8'h40, "R7 fire");
    wr_ctl(8'hAF, "R10 write in pulse");
    idle(1);
    rd_ctl("R10 discarded");
    wr_ctl(8'h40, "R10 tracker idle");
    idle(3);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done && exp_q.size() == 0);
        @(negedge clk);
      end
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule